// File: doc/BRIEF.md
# Memory Exerciser Front-End Sequencer

This block drives the word-level command port of a memory controller. After a synchronous reset it stays quiet until the controller reports that its own initialization has finished. It then runs a short self test on its own. Sixteen 64-bit words, each built from an address-dependent pattern, are written to addresses 0 to 15. Word 0 is then read back into a display register. Every access moves one 64-bit word, which the controller carries as four 16-bit beats of a length-4 burst.

After the self test the block obeys four push buttons. Two of them step a word address pointer up or down. The third reads the word at the pointer into the display register. The fourth writes a fixed constant word at the pointer. A three-bit switch field picks which byte of the display register appears on eight LEDs. A status LED blinks from a free-running counter.

Each access waits on the controller's handshakes: command accept, write completion and read-data valid. No fixed delay is counted, so latencies such as 22 cycles for a read or 25 cycles for a write are handled without change.

Top module: `memx_sequencer`

## Requirements
- R1: While `srst` is high, and after it falls until `init_done` is sampled high, `cmd_valid` stays low. A reset clears the display register to zero, so `leds` read 0. It also clears the blink counter, so `status_led` is 0.
- R2: After init, the block writes AUTO_WORDS (16) words to addresses 0, 1, … 15 in that order. A write starts only after the previous one has reported `wr_done`. Word a holds four 16-bit beats. Beat k sits in bits 16k+15:16k and equals {k as 4 bits, a[11:0]}.
- R3: After the last automatic write completes, the block reads address 0. The `rd_data` present on the cycle where `rd_valid` is high is captured into the display register.
- R4: A command stays on `cmd_valid` with stable `cmd_addr`, `cmd_write` and `cmd_wdata` until `cmd_ready` is high. Only one access is outstanding at a time. The next command waits for `wr_done` (writes) or `rd_valid` (reads).
- R5: `leds` equal bits 8s+7:8s of the display register, where s is `byte_sel`.
- R6: A rising edge on `btn_up` adds one to the address pointer and one on `btn_down` subtracts one, modulo 2^ADDR_W. The pointer is 0 when the self test ends. A held button acts once.
- R7: A rising edge on `btn_read` reads the word at the pointer into the display register.
- R8: A rising edge on `btn_write` writes FIXED_WORD at the pointer.
- R9: Button edges are acted on only while no access is in progress. Edges arriving during an access are dropped. When several edges arrive in the same idle cycle, only one is acted on, in the priority read, write, up, down.
- R10: A `rd_valid` pulse while no read is outstanding leaves the display register unchanged.
- R11: `status_led` is the top bit of a BLINK_W-bit counter that advances every clock. It therefore toggles every 2^(BLINK_W-1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| init_done | input | 1 | Controller initialization finished |
| cmd_ready | input | 1 | Controller accepts the presented command |
| cmd_valid | output | 1 | Command presented |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | ADDR_W | Word address of the command |
| cmd_wdata | output | 64 | Write word (four 16-bit beats, beat 0 in the low bits) |
| wr_done | input | 1 | Write completion pulse |
| rd_valid | input | 1 | Read data valid pulse |
| rd_data | input | 64 | Read word |
| btn_up | input | 1 | Step pointer up (debounced level) |
| btn_down | input | 1 | Step pointer down (debounced level) |
| btn_read | input | 1 | Read word at pointer |
| btn_write | input | 1 | Write fixed word at pointer |
| byte_sel | input | 3 | Byte of the display register shown on the LEDs |
| leds | output | 8 | Selected display byte |
| status_led | output | 1 | Blinking activity indicator |

## Verification
The bound checker watches the command handshake on every cycle: the command holds while not accepted, no command is issued before init, and no new command appears while an access is outstanding. It also checks that the display register moves only on a read-valid strobe and then takes that strobe's data, that the LEDs follow the register and switches, and that the status LED never stalls longer than half a blink period.

Only the bench's scenarios can show that the automatic sequence has the right order, addresses and patterns. The same holds for pointer wrap in both directions, the read-over-write-over-step priority, dropped presses during an access, a held button acting once, and the fixed-word readback. The bench's reference model tracks these with its own memory, pointer and expected-command queue.

// File: rtl/memx_pkg.sv
package memx_pkg;

  localparam int WORD_W     = 64;
  localparam int BEAT_W     = 16;
  localparam int BEATS      = WORD_W / BEAT_W;
  localparam int BEAT_TAG_W = 4;
  localparam int BEAT_LOW_W = BEAT_W - BEAT_TAG_W;
  localparam int LED_W      = 8;
  localparam int NUM_BYTES  = WORD_W / LED_W;
  localparam int SEL_W      = $clog2(NUM_BYTES);

  localparam int BTN_UP    = 0;
  localparam int BTN_DOWN  = 1;
  localparam int BTN_READ  = 2;
  localparam int BTN_WRITE = 3;
  localparam int NUM_BTN   = 4;

  typedef enum logic [3:0] {
    ST_WAIT_INIT,
    ST_AUTO_WR,
    ST_AUTO_WR_WAIT,
    ST_AUTO_RD,
    ST_AUTO_RD_WAIT,
    ST_IDLE,
    ST_USER_WR,
    ST_USER_WR_WAIT,
    ST_USER_RD,
    ST_USER_RD_WAIT
  } seq_state_t;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_READ,
    ACT_WRITE,
    ACT_UP,
    ACT_DOWN
  } user_act_t;

  // Self-test pattern: each beat carries its beat index over the low address bits.
  function automatic logic [WORD_W-1:0] seed_word(input logic [31:0] addr);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int k = 0; k < BEATS; k++) begin
      w[k*BEAT_W +: BEAT_W] = {BEAT_TAG_W'(k), addr[BEAT_LOW_W-1:0]};
    end
    return w;
  endfunction

  // One action per idle cycle, highest priority first.
  function automatic user_act_t pick_action(input logic [NUM_BTN-1:0] rise);
    if (rise[BTN_READ])       return ACT_READ;
    else if (rise[BTN_WRITE]) return ACT_WRITE;
    else if (rise[BTN_UP])    return ACT_UP;
    else if (rise[BTN_DOWN])  return ACT_DOWN;
    else                      return ACT_NONE;
  endfunction

  function automatic logic [LED_W-1:0] byte_of(input logic [WORD_W-1:0] w,
                                               input logic [SEL_W-1:0] sel);
    return w[sel*LED_W +: LED_W];
  endfunction

endpackage

// File: rtl/memx_edge_detect.sv
module memx_edge_detect #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         srst,
  input  logic [N-1:0] level,
  output logic [N-1:0] rise
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      logic prev_q;
      always_ff @(posedge clk) begin
        if (srst) prev_q <= 1'b0;
        else      prev_q <= level[i];
      end
      assign rise[i] = level[i] & ~prev_q;
    end
  endgenerate
endmodule

// File: rtl/memx_blinker.sv
module memx_blinker #(
  parameter int BLINK_W = 24
) (
  input  logic clk,
  input  logic srst,
  output logic led
);
  logic [BLINK_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (srst) cnt_q <= '0;
    else      cnt_q <= cnt_q + BLINK_W'(1);
  end

  assign led = cnt_q[BLINK_W-1];
endmodule

// File: rtl/memx_display.sv
module memx_display
  import memx_pkg::*;
(
  input  logic              clk,
  input  logic              srst,
  input  logic              capture,
  input  logic [WORD_W-1:0] rd_data,
  input  logic [SEL_W-1:0]  byte_sel,
  output logic [WORD_W-1:0] disp_q,
  output logic [LED_W-1:0]  leds
);
  always_ff @(posedge clk) begin
    if (srst)         disp_q <= '0;
    else if (capture) disp_q <= rd_data;
  end

  assign leds = byte_of(disp_q, byte_sel);
endmodule

// File: rtl/memx_fsm.sv
module memx_fsm
  import memx_pkg::*;
#(
  parameter int                ADDR_W     = 10,
  parameter int                AUTO_WORDS = 16,
  parameter logic [WORD_W-1:0] FIXED_WORD = 64'hFEED_0BAD_C0DE_5A5A
) (
  input  logic               clk,
  input  logic               srst,
  input  logic               init_done,
  input  logic               cmd_ready,
  input  logic               wr_done,
  input  logic               rd_valid,
  input  logic [NUM_BTN-1:0] btn_rise,
  output logic               cmd_valid,
  output logic               cmd_write,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic [WORD_W-1:0]  cmd_wdata,
  output logic               capture
);
  localparam int IDX_W = (AUTO_WORDS > 1) ? $clog2(AUTO_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(AUTO_WORDS - 1);

  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  user_act_t         act;
  logic              is_auto_wr, is_user_wr, is_auto_rd, in_rd_wait;

  assign act = (state_q == ST_IDLE) ? pick_action(btn_rise) : ACT_NONE;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_WAIT_INIT:    if (init_done) state_d = ST_AUTO_WR;
      ST_AUTO_WR:      if (cmd_ready) state_d = ST_AUTO_WR_WAIT;
      ST_AUTO_WR_WAIT: if (wr_done) begin
                         if (idx_q == LAST_IDX) state_d = ST_AUTO_RD;
                         else begin
                           idx_d   = idx_q + IDX_W'(1);
                           state_d = ST_AUTO_WR;
                         end
                       end
      ST_AUTO_RD:      if (cmd_ready) state_d = ST_AUTO_RD_WAIT;
      ST_AUTO_RD_WAIT: if (rd_valid)  state_d = ST_IDLE;
      ST_IDLE: begin
        unique case (act)
          ACT_READ:  state_d = ST_USER_RD;
          ACT_WRITE: state_d = ST_USER_WR;
          ACT_UP:    ptr_d   = ptr_q + ADDR_W'(1);
          ACT_DOWN:  ptr_d   = ptr_q - ADDR_W'(1);
          default:   ;
        endcase
      end
      ST_USER_WR:      if (cmd_ready) state_d = ST_USER_WR_WAIT;
      ST_USER_WR_WAIT: if (wr_done)   state_d = ST_IDLE;
      ST_USER_RD:      if (cmd_ready) state_d = ST_USER_RD_WAIT;
      ST_USER_RD_WAIT: if (rd_valid)  state_d = ST_IDLE;
      default:         state_d = ST_WAIT_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      state_q <= ST_WAIT_INIT;
      ptr_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      idx_q   <= idx_d;
    end
  end

  assign is_auto_wr = (state_q == ST_AUTO_WR);
  assign is_user_wr = (state_q == ST_USER_WR);
  assign is_auto_rd = (state_q == ST_AUTO_RD);
  assign in_rd_wait = (state_q == ST_AUTO_RD_WAIT) || (state_q == ST_USER_RD_WAIT);

  assign cmd_valid = is_auto_wr || is_user_wr || is_auto_rd || (state_q == ST_USER_RD);
  assign cmd_write = is_auto_wr || is_user_wr;

  always_comb begin
    if (is_auto_wr)      cmd_addr = ADDR_W'(idx_q);
    else if (is_auto_rd) cmd_addr = '0;
    else                 cmd_addr = ptr_q;
  end

  always_comb begin
    if (is_auto_wr)      cmd_wdata = seed_word(32'(idx_q));
    else if (is_user_wr) cmd_wdata = FIXED_WORD;
    else                 cmd_wdata = '0;
  end

  assign capture = rd_valid && in_rd_wait;
endmodule

// File: rtl/memx_sequencer.sv
module memx_sequencer
  import memx_pkg::*;
#(
  parameter int                ADDR_W     = 10,
  parameter int                AUTO_WORDS = 16,
  parameter int                BLINK_W    = 24,
  parameter logic [WORD_W-1:0] FIXED_WORD = 64'hFEED_0BAD_C0DE_5A5A
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              init_done,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [WORD_W-1:0] cmd_wdata,
  input  logic              wr_done,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  input  logic              btn_up,
  input  logic              btn_down,
  input  logic              btn_read,
  input  logic              btn_write,
  input  logic [SEL_W-1:0]  byte_sel,
  output logic [LED_W-1:0]  leds,
  output logic              status_led
);
  logic [NUM_BTN-1:0] btn_level;
  logic [NUM_BTN-1:0] btn_rise;
  logic               rd_capture;
  logic [WORD_W-1:0]  disp_word;

  always_comb begin
    btn_level            = '0;
    btn_level[BTN_UP]    = btn_up;
    btn_level[BTN_DOWN]  = btn_down;
    btn_level[BTN_READ]  = btn_read;
    btn_level[BTN_WRITE] = btn_write;
  end

  memx_edge_detect #(.N(NUM_BTN)) u_edges (
    .clk   (clk),
    .srst  (srst),
    .level (btn_level),
    .rise  (btn_rise)
  );

  memx_fsm #(
    .ADDR_W     (ADDR_W),
    .AUTO_WORDS (AUTO_WORDS),
    .FIXED_WORD (FIXED_WORD)
  ) u_fsm (
    .clk       (clk),
    .srst      (srst),
    .init_done (init_done),
    .cmd_ready (cmd_ready),
    .wr_done   (wr_done),
    .rd_valid  (rd_valid),
    .btn_rise  (btn_rise),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .capture   (rd_capture)
  );

  memx_display u_disp (
    .clk      (clk),
    .srst     (srst),
    .capture  (rd_capture),
    .rd_data  (rd_data),
    .byte_sel (byte_sel),
    .disp_q   (disp_word),
    .leds     (leds)
  );

  memx_blinker #(.BLINK_W(BLINK_W)) u_blink (
    .clk  (clk),
    .srst (srst),
    .led  (status_led)
  );
endmodule

// File: rtl/memx_sequencer_chk.sv
module memx_sequencer_chk
  import memx_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int BLINK_W = 24
) (
  input logic              clk,
  input logic              srst,
  input logic              init_done,
  input logic              cmd_ready,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [WORD_W-1:0] cmd_wdata,
  input logic              wr_done,
  input logic              rd_valid,
  input logic [WORD_W-1:0] rd_data,
  input logic [SEL_W-1:0]  byte_sel,
  input logic [LED_W-1:0]  leds,
  input logic              status_led,
  input logic              capture,
  input logic [WORD_W-1:0] disp_q
);
  localparam logic [BLINK_W:0] HALF = (BLINK_W+1)'(1) << (BLINK_W - 1);

  logic             init_seen, outstanding, out_is_rd, last_led;
  logic [BLINK_W:0] since_toggle;

  always_ff @(posedge clk) begin
    if (srst) begin
      init_seen    <= 1'b0;
      outstanding  <= 1'b0;
      out_is_rd    <= 1'b0;
      last_led     <= 1'b0;
      since_toggle <= '0;
    end else begin
      if (init_done) init_seen <= 1'b1;
      if (cmd_valid && cmd_ready) begin
        outstanding <= 1'b1;
        out_is_rd   <= !cmd_write;
      end else if (outstanding && (out_is_rd ? rd_valid : wr_done)) begin
        outstanding <= 1'b0;
      end
      last_led     <= status_led;
      since_toggle <= (status_led != last_led) ? '0 : since_toggle + 1'b1;
    end
  end

  a_r1_quiet_before_init: assert property (@(posedge clk) disable iff (srst)
    !init_seen |-> !cmd_valid);

  a_r4_hold_command: assert property (@(posedge clk) disable iff (srst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_write)
                                   && $stable(cmd_addr) && $stable(cmd_wdata)));

  a_r4_single_outstanding: assert property (@(posedge clk) disable iff (srst)
    outstanding |-> !cmd_valid);

  a_r3_capture_data: assert property (@(posedge clk) disable iff (srst)
    capture |=> (disp_q == $past(rd_data)));

  a_r10_display_needs_strobe: assert property (@(posedge clk) disable iff (srst)
    !rd_valid |=> $stable(disp_q));

  a_r5_leds_follow: assert property (@(posedge clk) disable iff (srst)
    ($stable(disp_q) && $stable(byte_sel)) |-> $stable(leds));

  a_r11_blink_alive: assert property (@(posedge clk) disable iff (srst)
    since_toggle <= HALF);
endmodule

bind memx_sequencer memx_sequencer_chk #(
  .ADDR_W  (ADDR_W),
  .BLINK_W (BLINK_W)
) u_chk (
  .clk        (clk),
  .srst       (srst),
  .init_done  (init_done),
  .cmd_ready  (cmd_ready),
  .cmd_valid  (cmd_valid),
  .cmd_write  (cmd_write),
  .cmd_addr   (cmd_addr),
  .cmd_wdata  (cmd_wdata),
  .wr_done    (wr_done),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .byte_sel   (byte_sel),
  .leds       (leds),
  .status_led (status_led),
  .capture    (rd_capture),
  .disp_q     (disp_word)
);

// File: tb/memx_sequencer_bench.sv
module memx_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 10;
  localparam int BLINK_W    = 5;
  localparam int RD_LAT     = 22;
  localparam int WR_LAT     = 25;
  localparam int WATCHDOG   = 100000;
  localparam logic [63:0] FIXED = 64'h1357_9BDF_2468_ACE0;

  logic              clk = 1'b0;
  logic              srst = 1'b1;
  logic              init_done = 1'b0;
  logic              cmd_ready = 1'b0;
  logic              cmd_valid, cmd_write;
  logic [ADDR_W-1:0] cmd_addr;
  logic [63:0]       cmd_wdata;
  logic              wr_done = 1'b0;
  logic              rd_valid = 1'b0;
  logic [63:0]       rd_data = '0;
  logic              btn_up = 0, btn_down = 0, btn_read = 0, btn_write = 0;
  logic [2:0]        byte_sel = '0;
  logic [7:0]        leds;
  logic              status_led;

  always #(CLK_PERIOD/2) clk = ~clk;

  memx_sequencer #(
    .ADDR_W(ADDR_W), .AUTO_WORDS(16), .BLINK_W(BLINK_W), .FIXED_WORD(FIXED)
  ) u_memx_sequencer (
    .clk(clk), .srst(srst), .init_done(init_done), .cmd_ready(cmd_ready),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .wr_done(wr_done), .rd_valid(rd_valid),
    .rd_data(rd_data), .btn_up(btn_up), .btn_down(btn_down),
    .btn_read(btn_read), .btn_write(btn_write), .byte_sel(byte_sel),
    .leds(leds), .status_led(status_led)
  );

  typedef struct { bit wr; int addr; logic [63:0] data; } exp_cmd_t;

  int          n_checks = 0, n_fails = 0, cyc = 0;
  bit          finished = 0;
  exp_cmd_t    expq[$];
  logic [63:0] mem [int];
  logic [63:0] model_disp = '0, ret_word = '0;
  int          blink = 0, ptr = 0;
  int          rd_cnt = 0, wr_cnt = 0, rd_addr = 0;
  bit          pending = 0, rd_drv = 0, stray_req = 0, init_model = 0;
  bit          s_v = 0, s_r = 0, s_w = 0;
  int          s_a = 0;
  logic [63:0] s_d = '0;

  function automatic logic [63:0] pat(int a);
    logic [11:0] lo;
    lo = a[11:0];
    return {4'd3, lo, 4'd2, lo, 4'd1, lo, 4'd0, lo};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    // effects of the posedge that just passed
    if (srst) begin
      blink = 0; model_disp = '0;
    end else begin
      blink = (blink + 1) % (1 << BLINK_W);
      if (init_done) init_model = 1;
      if (rd_drv) begin model_disp = ret_word; pending = 0; rd_drv = 0; end
      if (s_v && s_r) begin
        if (pending) chk(0, "R4", "command while access outstanding", 1, 0);
        if (expq.size() == 0) chk(0, "R4", "unexpected command addr", 64'(s_a), 0);
        else begin
          exp_cmd_t e = expq.pop_front();
          chk(s_w == e.wr, "R4", "command direction", 64'(s_w), 64'(e.wr));
          chk(s_a == e.addr, e.wr ? "R8" : "R7", "command address", 64'(s_a), 64'(e.addr));
          if (e.wr) chk(s_d == e.data, "R2", "write word", s_d, e.data);
        end
        pending = 1;
        if (s_w) begin mem[s_a] = s_d; wr_cnt = WR_LAT; end
        else begin rd_addr = s_a; rd_cnt = RD_LAT; end
      end
    end
    // controller responses for the next posedge
    wr_done = 0; rd_valid = 0;
    if (wr_cnt > 0) begin
      wr_cnt--;
      if (wr_cnt == 0) begin wr_done = 1; pending = 0; end
    end
    if (rd_cnt > 0) begin
      rd_cnt--;
      if (rd_cnt == 0) begin
        rd_valid = 1; rd_drv = 1;
        ret_word = mem.exists(rd_addr) ? mem[rd_addr] : 64'h0;
        rd_data  = ret_word;
      end
    end
    if (stray_req) begin
      rd_valid = 1; rd_data = 64'hDEAD_BEEF_DEAD_BEEF; stray_req = 0;
    end
    cmd_ready = (cyc % 3) != 1;
    #1;
    s_v = cmd_valid; s_r = cmd_ready; s_w = cmd_write;
    s_a = int'(cmd_addr); s_d = cmd_wdata;
    chk(leds == model_disp[byte_sel*8 +: 8], "R5", "leds", 64'(leds),
        64'(model_disp[byte_sel*8 +: 8]));
    chk(status_led == blink[BLINK_W-1], "R11", "status_led", 64'(status_led),
        64'(blink[BLINK_W-1]));
    if (!init_model && cmd_valid) chk(0, "R1", "cmd_valid before init", 1, 0);
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (guard < 600 && (expq.size() != 0 || pending || rd_drv)) begin
      tick(); guard++;
    end
    tick(); tick();
  endtask

  task automatic press(bit up, bit dn, bit rd, bit wr, int hold);
    btn_up = up; btn_down = dn; btn_read = rd; btn_write = wr;
    repeat (hold) tick();
    btn_up = 0; btn_down = 0; btn_read = 0; btn_write = 0;
    tick(); tick();
  endtask

  task automatic push_rd();
    exp_cmd_t e; e.wr = 0; e.addr = ptr; e.data = '0; expq.push_back(e);
  endtask

  task automatic push_wr();
    exp_cmd_t e; e.wr = 1; e.addr = ptr; e.data = FIXED; expq.push_back(e);
  endtask

  task automatic step(bit up, int times);
    for (int i = 0; i < times; i++) begin
      ptr = up ? (ptr + 1) % (1 << ADDR_W) : (ptr + (1 << ADDR_W) - 1) % (1 << ADDR_W);
      press(up, !up, 0, 0, 3);   // R6: held three cycles, one step
    end
  endtask

  task automatic sweep();
    for (int s = 0; s < 8; s++) begin byte_sel = 3'(s); tick(); end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL R4 watchdog: actual %0d cycles expected fewer than %0d", WATCHDOG, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (4) tick();
    chk(cmd_valid == 0 && leds == 0 && status_led == 0, "R1", "reset outputs",
        {cmd_valid, leds, status_led}, 0);
    srst = 0;
    repeat (10) tick();
    chk(cmd_valid == 0, "R1", "idle before init", 64'(cmd_valid), 0);
    // R2, R3: automatic write run and readback of word 0
    for (int a = 0; a < 16; a++) begin
      exp_cmd_t e; e.wr = 1; e.addr = a; e.data = pat(a); expq.push_back(e);
    end
    begin exp_cmd_t e; e.wr = 0; e.addr = 0; e.data = '0; expq.push_back(e); end
    init_done = 1;
    wait_idle();
    chk(model_disp == pat(0), "R3", "display after self test", model_disp, pat(0));
    chk(mem.num() == 16, "R2", "words written", 64'(mem.num()), 16);
    sweep();

    // R6, R7: step up three, read
    step(1, 3);
    push_rd(); press(0, 0, 1, 0, 3); wait_idle();
    chk(model_disp == pat(3), "R7", "read at pointer 3", model_disp, pat(3));
    sweep();

    // R9: up and down together -> up wins
    ptr = ptr + 1;
    press(1, 1, 0, 0, 2);
    push_rd(); press(0, 0, 1, 0, 1); wait_idle();
    chk(model_disp == pat(4), "R9", "up over down", model_disp, pat(4));

    // R6: wrap down past zero, R8: fixed write
    step(0, 5);
    chk(ptr == (1 << ADDR_W) - 1, "R6", "model pointer wrap", 64'(ptr), 64'((1 << ADDR_W) - 1));
    push_wr(); press(0, 0, 0, 1, 2); wait_idle();
    push_rd(); press(0, 0, 1, 0, 2); wait_idle();
    chk(model_disp == FIXED, "R8", "fixed word readback", model_disp, FIXED);
    sweep();

    // R6: wrap up to zero
    step(1, 1);
    push_rd(); press(0, 0, 1, 0, 2); wait_idle();
    chk(model_disp == pat(0), "R6", "wrap up to zero", model_disp, pat(0));

    // R9: presses during an access are dropped
    push_rd();
    btn_read = 1; tick(); btn_read = 0; tick(); tick();
    press(1, 0, 0, 1, 2);
    press(0, 1, 0, 0, 2);
    wait_idle();
    push_rd(); press(0, 0, 1, 0, 2); wait_idle();
    chk(model_disp == pat(0), "R9", "busy presses ignored", model_disp, pat(0));

    // R9: read beats write in the same cycle
    step(1, 2);
    push_rd(); press(0, 0, 1, 1, 2); wait_idle();
    chk(model_disp == pat(2), "R9", "read over write", model_disp, pat(2));
    chk(mem[2] == pat(2), "R9", "no write on tie", mem[2], pat(2));

    // R10: stray read strobe in idle
    byte_sel = 3'd5;
    stray_req = 1; tick(); tick(); tick();
    chk(leds == pat(2)[47:40], "R10", "stray strobe ignored", 64'(leds), 64'(pat(2)[47:40]));

    // R11: blink observed across a few periods
    repeat (70) tick();
    chk(expq.size() == 0, "R4", "all commands issued", 64'(expq.size()), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule